// File: doc/BRIEF.md
# Priority-Stacking Vectored Interrupt Controller

This block arbitrates 32 interrupt inputs for a processor and drives an active-low interrupt request line. Every source has its own enable bit, a 3-bit priority (7 is the most urgent) and a choice between latching rising edges or following its input level. Source 0 is reserved as the fast-interrupt source. It drives its own active-low line and takes no part in the priority arbitration.

Software reaches the controller through a simple register port. Writes take effect on the clock edge. Read data is combinational in the cycle the read strobe is high. Reading the vector register acknowledges the winning source: its priority is pushed onto an 8-entry nesting stack and its number is recorded. An end-of-service write pops the stack. When nothing qualifies, the read returns zero and changes nothing. A debug mode lets a monitor read the vector register without acknowledging anything. A later write to that register commits the acknowledge captured at the most recent read.

Register map (4-bit address): 0 vector (read acknowledges; a write commits in debug mode), 1 enable-set, 2 enable-clear, 3 enable status, 4 software-set, 5 software-clear, 6 end-of-service, 8 configuration, 9 control, 10 service status. Reads of write-only addresses return zero.

Top module: `pri_intc`

## Requirements
- R1: A write to address 1 sets the enable bits that are 1 in the data, and a write to address 2 clears them. Address 3 reads back the 32-bit enable mask. The mask is all zero after reset.
- R2: A disabled source has no effect on arbitration or on the request line, and it does not stop a lower-priority enabled source from winning. Its latched edge stays pending and shows once the source is enabled.
- R3: An edge-mode source latches a pending bit on a rising edge of its input. The request can appear on the cycle after that edge. The bit is cleared when the source is acknowledged.
- R4: A level-mode source is pending exactly while its input is high. Software-set and software-clear writes have no effect on a level-mode source.
- R5: A write to address 4 makes the edge-mode sources named in the data pending, and a write to address 5 removes their pending bits.
- R6: A source qualifies when it is enabled, pending and has a priority above the current level. Every source qualifies when the stack is empty. The winner is the qualifying source with the highest priority, and on a tie the lower source number wins. irq_n is low exactly when some source qualifies.
- R7: In normal mode, reading address 0 while a source qualifies returns bit 31 = 1, the priority in bits 10:8 and the source number in bits 4:0. The same read pushes that priority and records the source number. Address 10 reads the source number in bits 4:0, the current level in bits 10:8, and bit 16 = 1 when the stack is not empty.
- R8: Reading address 0 when no source qualifies returns all zeros. The current level, the stack and the recorded source number do not change.
- R9: A write to address 6 pops one stack entry and restores the previous level. It has no effect when the stack is empty. The stack never holds more than 8 entries.
- R10: Bit 0 of address 9 enables debug mode. In debug mode a read of address 0 returns the vector and changes no state. A write of any value to address 0 then commits the push, the source-number update and the acknowledge captured at the most recent read. A write with no captured winner changes nothing.
- R11: fiq_n is low exactly while source 0 is enabled and pending. Source 0 never wins the priority arbitration.
- R12: After reset irq_n and fiq_n are high, the stack is empty and service status reads zero.
- R13: Address 8 configures one source: bits 4:0 select it, bits 10:8 give its priority, and bit 16 = 1 selects edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| src_in | input | 32 | Interrupt source inputs |
| irq_n | output | 1 | Active-low interrupt request |
| fiq_n | output | 1 | Active-low fast-interrupt request |

## Verification
The assertions check on every cycle the bounds and the accounting of the nesting stack. A normal-mode acknowledge adds exactly one level. An end-of-service write removes exactly one. A zero-returning vector read and a debug-mode read leave the depth alone. Whenever the vector register is read, the request line must agree with whether the read returned a vector.

Only the bench scenarios can show the rest. These are the winner choice for each source and priority, the tie rule, how masking interacts with latched edges, the difference between level and edge sources, and the restore order over a full eight-deep nest. They also cover the two-step read-then-write commit of debug mode.

// File: rtl/pri_intc_pkg.sv
package pri_intc_pkg;
    localparam int AW = 4;

    localparam logic [AW-1:0] A_VEC   = 4'd0;
    localparam logic [AW-1:0] A_MSET  = 4'd1;
    localparam logic [AW-1:0] A_MCLR  = 4'd2;
    localparam logic [AW-1:0] A_MSTAT = 4'd3;
    localparam logic [AW-1:0] A_SSET  = 4'd4;
    localparam logic [AW-1:0] A_SCLR  = 4'd5;
    localparam logic [AW-1:0] A_EOS   = 4'd6;
    localparam logic [AW-1:0] A_CFG   = 4'd8;
    localparam logic [AW-1:0] A_CTRL  = 4'd9;
    localparam logic [AW-1:0] A_STAT  = 4'd10;

    // Field positions shared by the vector, status and configuration words
    localparam int F_PRIO_LSB  = 8;
    localparam int F_FLAG_BIT  = 16;
    localparam int F_VALID_BIT = 31;
endpackage

// File: rtl/pri_intc_pend.sv
// One source's pending logic: edge latch or level follow-through.
module pri_intc_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic src_in,
    input  logic edge_mode,
    input  logic set_cmd,
    input  logic clr_cmd,
    input  logic ack,
    output logic pend
);
    typedef struct packed {
        logic prev;
        logic lat;
    } cell_t;

    cell_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.prev = src_in;
        if (edge_mode)
            c_d.lat = (c_q.lat & ~(ack | clr_cmd)) | (src_in & ~c_q.prev) | set_cmd;
        else
            c_d.lat = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pend = edge_mode ? c_q.lat : src_in;
endmodule

// File: rtl/pri_intc_arb.sv
// Picks the highest-priority qualifying source; lower index wins a tie.
// Index 0 is the fast source and is left out of this arbitration.
module pri_intc_arb #(
    parameter int NSRC = 32,
    parameter int PW   = 3,
    localparam int SW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]    req,
    input  logic [NSRC*PW-1:0] prio,
    input  logic               cur_valid,
    input  logic [PW-1:0]      cur_lvl,
    output logic               win_valid,
    output logic [SW-1:0]      win_src,
    output logic [PW-1:0]      win_prio
);
    always_comb begin
        win_valid = 1'b0;
        win_src   = '0;
        win_prio  = '0;
        for (int i = NSRC - 1; i >= 1; i--) begin
            if (req[i] && (!cur_valid || prio[i*PW +: PW] > cur_lvl)
                && (!win_valid || prio[i*PW +: PW] >= win_prio)) begin
                win_valid = 1'b1;
                win_src   = SW'(i);
                win_prio  = prio[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/pri_intc.sv
module pri_intc
    import pri_intc_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int PW    = 3,
    parameter int DEPTH = 8,
    parameter int DW    = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_rd,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NSRC-1:0] src_in,
    output logic            irq_n,
    output logic            fiq_n
);
    localparam int SW = $clog2(NSRC);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [NSRC-1:0]     mask;
        logic [NSRC-1:0]     edge_sel;
        logic [NSRC*PW-1:0]  prio;
        logic                dbg;
        logic [SW-1:0]       srcnum;
        logic [DEPTH*PW-1:0] stack;
        logic [CW-1:0]       depth;
        logic                hold_v;
        logic [SW-1:0]       hold_src;
        logic [PW-1:0]       hold_prio;
    } st_t;

    st_t st_d, st_q;

    logic [NSRC-1:0] pend, req, set_cmd, clr_cmd, ack;
    logic            cur_valid;
    logic [PW-1:0]   cur_lvl;
    logic            win_valid;
    logic [SW-1:0]   win_src;
    logic [PW-1:0]   win_prio;
    logic [CW-1:0]   depth_now;
    logic            dbg_now;
    int              top_i;

    // Per-source pending cells
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        pri_intc_pend u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_in    (src_in[g]),
            .edge_mode (st_q.edge_sel[g]),
            .set_cmd   (set_cmd[g]),
            .clr_cmd   (clr_cmd[g]),
            .ack       (ack[g]),
            .pend      (pend[g])
        );
    end

    assign set_cmd = (reg_wr && reg_addr == A_SSET) ? reg_wdata[NSRC-1:0] : '0;
    assign clr_cmd = (reg_wr && reg_addr == A_SCLR) ? reg_wdata[NSRC-1:0] : '0;
    assign req     = pend & st_q.mask & ~NSRC'(1);

    assign cur_valid = (st_q.depth != '0);
    assign top_i     = cur_valid ? int'(st_q.depth) - 1 : 0;
    assign cur_lvl   = cur_valid ? st_q.stack[top_i*PW +: PW] : '0;

    pri_intc_arb #(.NSRC(NSRC), .PW(PW)) u_arb (
        .req       (req),
        .prio      (st_q.prio),
        .cur_valid (cur_valid),
        .cur_lvl   (cur_lvl),
        .win_valid (win_valid),
        .win_src   (win_src),
        .win_prio  (win_prio)
    );

    // Next-state computation
    always_comb begin
        logic          push;
        logic [PW-1:0] push_prio;
        logic [SW-1:0] push_src;
        int            idx;

        st_d      = st_q;
        ack       = '0;
        push      = 1'b0;
        push_prio = '0;
        push_src  = '0;
        idx       = int'(reg_wdata[SW-1:0]);

        if (reg_wr && reg_addr == A_MSET) st_d.mask = st_q.mask | reg_wdata[NSRC-1:0];
        if (reg_wr && reg_addr == A_MCLR) st_d.mask = st_q.mask & ~reg_wdata[NSRC-1:0];
        if (reg_wr && reg_addr == A_CFG) begin
            st_d.prio[idx*PW +: PW] = reg_wdata[F_PRIO_LSB +: PW];
            st_d.edge_sel[idx]      = reg_wdata[F_FLAG_BIT];
        end
        if (reg_wr && reg_addr == A_CTRL) st_d.dbg = reg_wdata[0];

        // End of service pops one level
        if (reg_wr && reg_addr == A_EOS && cur_valid)
            st_d.depth = st_q.depth - 1'b1;

        // Vector read: acknowledge now, or capture only in debug mode
        if (reg_rd && reg_addr == A_VEC) begin
            if (st_q.dbg) begin
                st_d.hold_v    = win_valid;
                st_d.hold_src  = win_src;
                st_d.hold_prio = win_prio;
            end else if (win_valid) begin
                push      = 1'b1;
                push_prio = win_prio;
                push_src  = win_src;
            end
        end

        // Debug commit of the captured acknowledge
        if (reg_wr && reg_addr == A_VEC && st_q.dbg && st_q.hold_v) begin
            push        = 1'b1;
            push_prio   = st_q.hold_prio;
            push_src    = st_q.hold_src;
            st_d.hold_v = 1'b0;
        end

        if (push && st_d.depth < CW'(DEPTH)) begin
            st_d.stack[int'(st_d.depth)*PW +: PW] = push_prio;
            st_d.depth                            = st_d.depth + 1'b1;
            st_d.srcnum                           = push_src;
            ack[push_src]                         = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read data
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                A_VEC: if (win_valid) begin
                    reg_rdata[SW-1:0]             = win_src;
                    reg_rdata[F_PRIO_LSB +: PW]   = win_prio;
                    reg_rdata[F_VALID_BIT]        = 1'b1;
                end
                A_MSTAT: reg_rdata[NSRC-1:0] = st_q.mask;
                A_STAT: begin
                    reg_rdata[SW-1:0]           = st_q.srcnum;
                    reg_rdata[F_PRIO_LSB +: PW] = cur_lvl;
                    reg_rdata[F_FLAG_BIT]       = cur_valid;
                end
                default: reg_rdata = '0;
            endcase
        end
    end

    assign irq_n     = ~win_valid;
    assign fiq_n     = ~(st_q.mask[0] & pend[0]);
    assign depth_now = st_q.depth;
    assign dbg_now   = st_q.dbg;
endmodule

// File: rtl/pri_intc_chk.sv
module pri_intc_chk
    import pri_intc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_rdata,
    input logic          irq_n,
    input logic [CW-1:0] depth,
    input logic          dbg
);
    // R9: stack bound
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CW'(DEPTH));

    // R7: a normal acknowledging read adds one level
    a_r7_push_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == A_VEC && !dbg && reg_rdata != '0)
        |=> depth == CW'($past(depth) + 1'b1));

    // R8: a zero read leaves the level alone
    a_r8_spurious_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == A_VEC && reg_rdata == '0)
        |=> $stable(depth));

    // R10: debug reads have no side effect on the stack
    a_r10_debug_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == A_VEC && dbg) |=> $stable(depth));

    // R9: end of service pops one level
    a_r9_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && reg_addr == A_EOS && depth != '0)
        |=> depth == CW'($past(depth) - 1'b1));

    // R6: the request line agrees with the vector read
    a_r6_irq_matches_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_VEC) |-> (irq_n == (reg_rdata == '0)));
endmodule

bind pri_intc pri_intc_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .irq_n     (irq_n),
    .depth     (depth_now),
    .dbg       (dbg_now)
);

// File: tb/pri_intc_test.sv
module pri_intc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] src_in = '0;
    logic        irq_n, fiq_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pri_intc uut (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_in(src_in), .irq_n(irq_n), .fiq_n(fiq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        src_in = v;
        @(negedge clk);
        src_in = '0;
    endtask

    task automatic cfg(input int s, input int p, input bit e);
        wr(4'd8, (32'(e) << 16) | (32'(p) << 8) | 32'(s));
    endtask

    function automatic logic [31:0] vecv(input int p, input int s);
        return 32'h8000_0000 | (32'(p) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] stat(input bit v, input int l, input int s);
        return (32'(v) << 16) | (32'(l) << 8) | 32'(s);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        #1;
        chk("R12 irq_n", 32'(irq_n), 32'd1);
        chk("R12 fiq_n", 32'(fiq_n), 32'd1);
        rd(4'd3, d); chk("R12/R1 mask", d, 0);
        rd(4'd10, d); chk("R12 status", d, 0);
        rd(4'd0, d); chk("R12/R8 vector", d, 0);

        // R1 mask set/clear sweep
        m = '0;
        for (int i = 0; i < 32; i++) begin
            wr(4'd1, 32'(1) << i); m |= 32'(1) << i;
            rd(4'd3, d); chk("R1 set", d, m);
        end
        for (int i = 0; i < 32; i += 2) begin
            wr(4'd2, 32'(1) << i); m &= ~(32'(1) << i);
            rd(4'd3, d); chk("R1 clear", d, m);
        end
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd3, d); chk("R1 clear all", d, 0);

        // R13 configure every source edge, priority = index mod 8
        for (int s = 0; s < 32; s++) cfg(s, s % 8, 1'b1);
        wr(4'd5, 32'hFFFF_FFFF);

        // R3/R7/R9/R13 sweep over every arbitrated source
        for (int s = 1; s < 32; s++) begin
            wr(4'd2, 32'hFFFF_FFFF);
            wr(4'd1, 32'(1) << s);
            pulse(32'(1) << s);
            chk("R3 edge raises irq", 32'(irq_n), 0);
            rd(4'd0, d); chk("R7/R13 vector", d, vecv(s % 8, s));
            chk("R3 ack clears", 32'(irq_n), 1);
            rd(4'd10, d); chk("R7 status", d, stat(1, s % 8, s));
            wr(4'd6, 0);
            rd(4'd10, d); chk("R9 pop to empty", d, stat(0, 0, s));
        end

        // R2 disabled source
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd1, 32'(1) << 3);
        pulse((32'(1) << 31) | (32'(1) << 3));
        rd(4'd0, d); chk("R2 masked higher loses", d, vecv(3, 3));
        chk("R2 masked no irq", 32'(irq_n), 1);
        wr(4'd6, 0);
        wr(4'd1, 32'(1) << 31);
        chk("R2 latched shows when enabled", 32'(irq_n), 0);
        rd(4'd0, d); chk("R2 vector", d, vecv(7, 31));
        wr(4'd6, 0);
        wr(4'd5, 32'hFFFF_FFFF);

        // R6 tie and ordering
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd1, (32'(1) << 3) | (32'(1) << 5) | (32'(1) << 13));
        pulse((32'(1) << 3) | (32'(1) << 5) | (32'(1) << 13));
        rd(4'd0, d); chk("R6 tie lower index", d, vecv(5, 5));
        chk("R6 equal prio not above", 32'(irq_n), 1);
        wr(4'd6, 0);
        chk("R6 irq after pop", 32'(irq_n), 0);
        rd(4'd0, d); chk("R6 second", d, vecv(5, 13));
        wr(4'd6, 0);
        rd(4'd0, d); chk("R6 third", d, vecv(3, 3));
        wr(4'd6, 0);

        // R9 eight-deep nest
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd1, 32'h0000_FF00);
        for (int k = 0; k < 8; k++) begin
            pulse(32'(1) << (8 + k));
            chk("R6 nested raise", 32'(irq_n), 0);
            rd(4'd0, d); chk("R7 nested vector", d, vecv(k, 8 + k));
            rd(4'd10, d); chk("R7 nested level", d, stat(1, k, 8 + k));
        end
        for (int k = 7; k >= 1; k--) begin
            wr(4'd6, 0);
            rd(4'd10, d); chk("R9 restore", d, stat(1, k - 1, 15));
        end
        wr(4'd6, 0);
        rd(4'd10, d); chk("R9 empty", d, stat(0, 0, 15));
        wr(4'd6, 0);
        rd(4'd10, d); chk("R9 pop on empty", d, stat(0, 0, 15));

        // R8 spurious read with a level stacked
        pulse(32'(1) << 14);
        rd(4'd0, d); chk("R8 setup", d, vecv(6, 14));
        pulse(32'(1) << 10);
        chk("R6 lower stays off", 32'(irq_n), 1);
        rd(4'd0, d); chk("R8 spurious zero", d, 0);
        rd(4'd10, d); chk("R8 level unchanged", d, stat(1, 6, 14));
        wr(4'd6, 0);
        chk("R6 lower after pop", 32'(irq_n), 0);
        rd(4'd0, d); chk("R8 pending kept", d, vecv(2, 10));
        wr(4'd6, 0);

        // R4 level source
        cfg(7, 3, 1'b0);
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd1, 32'(1) << 7);
        @(negedge clk); src_in[7] = 1'b1; #1;
        chk("R4 level raise", 32'(irq_n), 0);
        rd(4'd0, d); chk("R4 vector", d, vecv(3, 7));
        chk("R4 stacked", 32'(irq_n), 1);
        wr(4'd6, 0);
        chk("R4 still high input", 32'(irq_n), 0);
        wr(4'd5, 32'(1) << 7);
        chk("R4 sw clear ignored", 32'(irq_n), 0);
        @(negedge clk); src_in[7] = 1'b0; #1;
        chk("R4 follows input", 32'(irq_n), 1);
        wr(4'd4, 32'(1) << 7);
        chk("R4 sw set ignored", 32'(irq_n), 1);
        rd(4'd0, d); chk("R4 nothing pending", d, 0);

        // R5 software set/clear
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd1, 32'(1) << 9);
        wr(4'd4, 32'(1) << 9);
        chk("R5 set", 32'(irq_n), 0);
        wr(4'd5, 32'(1) << 9);
        chk("R5 clear", 32'(irq_n), 1);
        wr(4'd4, 32'(1) << 9);
        rd(4'd0, d); chk("R5 vector", d, vecv(1, 9));
        wr(4'd6, 0);

        // R10 debug mode
        wr(4'd9, 1);
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd1, 32'(1) << 4);
        wr(4'd4, 32'(1) << 4);
        chk("R10 raise", 32'(irq_n), 0);
        rd(4'd0, d); chk("R10 debug vector", d, vecv(4, 4));
        rd(4'd10, d); chk("R10 no side effect", d, stat(0, 0, 9));
        chk("R10 still pending", 32'(irq_n), 0);
        rd(4'd0, d); chk("R10 repeat read", d, vecv(4, 4));
        wr(4'd0, 32'h1234_5678);
        rd(4'd10, d); chk("R10 commit", d, stat(1, 4, 4));
        chk("R10 acked", 32'(irq_n), 1);
        wr(4'd6, 0);
        wr(4'd0, 0);
        rd(4'd10, d); chk("R10 empty commit", d, stat(0, 0, 4));
        wr(4'd9, 0);

        // R11 fast source
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd1, 1);
        pulse(1);
        chk("R11 fiq low", 32'(fiq_n), 0);
        chk("R11 no irq", 32'(irq_n), 1);
        rd(4'd0, d); chk("R11 not arbitrated", d, 0);
        wr(4'd5, 1);
        chk("R11 fiq cleared", 32'(fiq_n), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule